// File: doc/BRIEF.md
# Misrouted Cell Detector and Header Capture

This block sits beside the receive lookup stage of a multi-port cell switch. For every cell header it is shown, it decides whether the cell can be routed. A cell is counted as misrouted for any of three reasons: both of its route-valid flags are clear, its VCI exceeds the limit configured for the port, or a port with VPI checking turned on sees a nonzero VPI bit above the configured used width. Each of the three reasons feeds a sticky interrupt flag. Each flag has its own enable, and software clears a flag by writing one to it.

For debugging, the block also keeps the 32-bit header of one chosen misrouted cell and the port it came from. Capture is one-shot. Software arms it, and the first misrouted cell that follows from a port in the capture-select mask is stored. Every later cell is ignored until software arms again. A latched bit shows that the stored header is fresh. When the switch runs as a PHY-side device, every cell is checked against the port 0 limits.

Top module: `misroute_monitor`

## Requirements
- R1: After reset, `irq_flags`, `cap_hi`, `cap_lo`, `cap_port` and `cap_latched` are all zero, and capture is not armed.
- R2: The header word is laid out as VPI in bits 31:20, VCI in bits 19:4 and PTI/CLP in bits 3:0. A cell from an enabled port with `hdr_route == 2'b00` sets the general flag `irq_flags[0]`. A cell with any other route value and no other fault sets no flag.
- R3: A cell whose VCI is greater than the 16-bit limit for its port sets both `irq_flags[1]` and `irq_flags[0]`. Port p's limit is `cfg_vci_max[16p+15:16p]`.
- R4: When `cfg_vpi_chk[p]` is 1, a cell whose VPI has any bit at position `cfg_vpi_used` or above set raises `irq_flags[2]` and `irq_flags[0]`. When `cfg_vpi_chk[p]` is 0, those VPI bits have no effect.
- R5: An event can set `irq_flags[k]` only while `cfg_irq_en[k]` is 1.
- R6: A set flag stays set until `irq_clear[k]` is pulsed. If an event and a clear for the same flag fall in the same cycle, the flag stays set.
- R7: While capture is armed, the first misrouted cell from a port whose `cfg_cap_sel` bit is 1 loads its header bits 31:16 into `cap_hi`, bits 15:0 into `cap_lo` and its port into `cap_port`. It also sets `cap_latched` and disarms capture. Later cells leave these outputs unchanged.
- R8: A pulse on `arm_capture` arms capture and clears `cap_latched`, and leaves `cap_hi`, `cap_lo` and `cap_port` unchanged. A misrouted cell in the same cycle as the arm pulse is not captured.
- R9: A cell from a port whose `cfg_port_en` bit is 0 has no effect on any flag or on the capture state.
- R10: While `cfg_phy_mode` is 1, every cell is checked against the port 0 VCI limit and the port 0 VPI-check bit, whatever port it arrived on.
- R11: Flags and capture registers change on the first rising edge at which `hdr_valid` is sampled high, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | A header is presented this cycle |
| hdr_port | input | 2 | Receive port of the header |
| hdr_route | input | 2 | Route-valid flags from the lookup entry |
| hdr_word | input | 32 | First four header bytes |
| cfg_port_en | input | 4 | Per-port monitoring enable |
| cfg_vpi_chk | input | 4 | Per-port unused-VPI check enable |
| cfg_vci_max | input | 64 | Per-port VCI upper limit, 16 bits each |
| cfg_vpi_used | input | 4 | Number of low VPI bits in use |
| cfg_phy_mode | input | 1 | Check all cells against port 0 settings |
| cfg_irq_en | input | 3 | Enables for general, VCI and VPI flags |
| cfg_cap_sel | input | 4 | Ports allowed to load the capture registers |
| arm_capture | input | 1 | Pulse: arm one-shot capture |
| irq_clear | input | 3 | Write-one-to-clear pulses for the flags |
| irq_flags | output | 3 | Sticky flags: [0] misrouted, [1] VCI range, [2] VPI range |
| cap_hi | output | 16 | Captured header bits 31:16 |
| cap_lo | output | 16 | Captured header bits 15:0 |
| cap_port | output | 2 | Port of the captured header |
| cap_latched | output | 1 | A header was captured since the last arm |

## Verification
The assertions watch every cycle for four properties. Set flags are held until cleared, and a set wins over a simultaneous clear. The captured bytes stay frozen while latched, and an arm pulse clears the latched bit without touching the data. A new capture always comes from a selected, misrouted cell. A disabled port never raises a flag. The fault classification itself can only be shown by the bench scenarios: the VCI limit compare, the VPI mask at the configured width, the per-port check bit and the PHY-mode use of port 0 settings. A behavioural model in the bench checks each of these against the outputs on every clock.

// File: rtl/misroute_pkg.sv
package misroute_pkg;
  localparam int IRQ_GEN = 0;
  localparam int IRQ_VCI = 1;
  localparam int IRQ_VPI = 2;
  localparam int NUM_IRQ = 3;

  typedef struct packed {
    logic vpi_over;
    logic vci_over;
    logic bad;
  } fault_t;
endpackage

// File: rtl/misroute_classify.sv
module misroute_classify #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 2,
  parameter int VPI_W     = 12,
  parameter int VCI_W     = 16,
  parameter int VPIU_W    = 4,
  parameter int HDR_W     = 32
) (
  input  logic                       hdr_valid,
  input  logic [PORT_W-1:0]          hdr_port,
  input  logic [1:0]                 hdr_route,
  input  logic [HDR_W-1:0]           hdr_word,
  input  logic [NUM_PORTS-1:0]       cfg_port_en,
  input  logic [NUM_PORTS-1:0]       cfg_vpi_chk,
  input  logic [NUM_PORTS*VCI_W-1:0] cfg_vci_max,
  input  logic [VPIU_W-1:0]          cfg_vpi_used,
  input  logic                       cfg_phy_mode,
  output misroute_pkg::fault_t       fault,
  output logic                       port_live
);
  localparam int VCI_LSB = HDR_W - VPI_W - VCI_W;

  int               src_idx;
  int               lkp_idx;
  logic [VPI_W-1:0] vpi_val;
  logic [VCI_W-1:0] vci_val;
  logic [VCI_W-1:0] vci_lim;
  logic [VPI_W-1:0] vpi_spare;
  logic             vci_bad;
  logic             vpi_bad;

  always_comb begin
    src_idx = int'(hdr_port);
    if (src_idx >= NUM_PORTS) begin
      src_idx = 0;
    end
    lkp_idx = cfg_phy_mode ? 0 : src_idx;
    vpi_val = hdr_word[HDR_W-1 -: VPI_W];
    vci_val = hdr_word[VCI_LSB +: VCI_W];
    vci_lim = cfg_vci_max[lkp_idx*VCI_W +: VCI_W];
    for (int b = 0; b < VPI_W; b++) begin
      vpi_spare[b] = (b >= int'(cfg_vpi_used));
    end
    port_live = hdr_valid && (int'(hdr_port) < NUM_PORTS) && cfg_port_en[src_idx];
    vci_bad   = vci_val > vci_lim;
    vpi_bad   = cfg_vpi_chk[lkp_idx] && |(vpi_val & vpi_spare);
    fault.vci_over = port_live && vci_bad;
    fault.vpi_over = port_live && vpi_bad;
    fault.bad      = port_live && ((hdr_route == 2'b00) || vci_bad || vpi_bad);
  end
endmodule

// File: rtl/misroute_irq.sv
module misroute_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] flag_d;
  logic [N-1:0] flag_q;

  generate
    for (genvar k = 0; k < N; k++) begin : g_flag
      always_comb begin
        flag_d[k] = (flag_q[k] && !clr[k]) || (evt[k] && en[k]);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flag_q[k] <= 1'b0;
        end else begin
          flag_q[k] <= flag_d[k];
        end
      end

      p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flags[k] && !clr[k] |=> flags[k])
        else $error("flag %0d dropped without clear", k);

      p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt[k] && en[k] |=> flags[k])
        else $error("flag %0d missed enabled event", k);

      p_enable_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !flags[k] && !en[k] |=> !flags[k])
        else $error("flag %0d set while disabled", k);
    end
  endgenerate

  assign flags = flag_q;
endmodule

// File: rtl/misroute_capture.sv
module misroute_capture #(
  parameter int PORT_W = 2,
  parameter int HDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              hit,
  input  logic              sel,
  input  logic [HDR_W-1:0]  hdr_word,
  input  logic [PORT_W-1:0] hdr_port,
  output logic [HDR_W/2-1:0] cap_hi,
  output logic [HDR_W/2-1:0] cap_lo,
  output logic [PORT_W-1:0] cap_port,
  output logic              cap_latched
);
  localparam int HALF_W = HDR_W / 2;

  logic              armed_q, armed_d;
  logic              latched_q, latched_d;
  logic              take;
  logic [HALF_W-1:0] hi_q, lo_q;
  logic [PORT_W-1:0] port_q;

  always_comb begin
    take      = armed_q && hit && sel && !arm;
    armed_d   = armed_q;
    latched_d = latched_q;
    if (arm) begin
      armed_d   = 1'b1;
      latched_d = 1'b0;
    end else if (take) begin
      armed_d   = 1'b0;
      latched_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      latched_q <= 1'b0;
    end else begin
      armed_q   <= armed_d;
      latched_q <= latched_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      port_q <= '0;
    end else if (take) begin
      hi_q   <= hdr_word[HDR_W-1 -: HALF_W];
      lo_q   <= hdr_word[HALF_W-1:0];
      port_q <= hdr_port;
    end
  end

  assign cap_hi      = hi_q;
  assign cap_lo      = lo_q;
  assign cap_port    = port_q;
  assign cap_latched = latched_q;

  p_frozen_while_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_latched && !arm |=> $stable(cap_hi) && $stable(cap_lo) && $stable(cap_port) && cap_latched)
    else $error("capture changed while latched");

  p_new_capture_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_latched && !arm && !(hit && sel) |=> !cap_latched)
    else $error("capture without selected misrouted cell");

  p_arm_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !cap_latched && $stable(cap_hi) && $stable(cap_lo) && $stable(cap_port))
    else $error("arm did not clear latch or altered data");
endmodule

// File: rtl/misroute_monitor.sv
module misroute_monitor #(
  parameter int NUM_PORTS = 4,
  parameter int VPI_W     = 12,
  parameter int VCI_W     = 16,
  parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  parameter int VPIU_W    = $clog2(VPI_W + 1),
  parameter int HDR_W     = VPI_W + VCI_W + 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hdr_valid,
  input  logic [PORT_W-1:0]          hdr_port,
  input  logic [1:0]                 hdr_route,
  input  logic [HDR_W-1:0]           hdr_word,
  input  logic [NUM_PORTS-1:0]       cfg_port_en,
  input  logic [NUM_PORTS-1:0]       cfg_vpi_chk,
  input  logic [NUM_PORTS*VCI_W-1:0] cfg_vci_max,
  input  logic [VPIU_W-1:0]          cfg_vpi_used,
  input  logic                       cfg_phy_mode,
  input  logic [2:0]                 cfg_irq_en,
  input  logic [NUM_PORTS-1:0]       cfg_cap_sel,
  input  logic                       arm_capture,
  input  logic [2:0]                 irq_clear,
  output logic [2:0]                 irq_flags,
  output logic [HDR_W/2-1:0]         cap_hi,
  output logic [HDR_W/2-1:0]         cap_lo,
  output logic [PORT_W-1:0]          cap_port,
  output logic                       cap_latched
);
  import misroute_pkg::*;

  fault_t             fault;
  logic               port_live;
  logic               sel_hit;
  logic [NUM_IRQ-1:0] irq_evt;

  misroute_classify #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .VPI_W(VPI_W),
    .VCI_W(VCI_W), .VPIU_W(VPIU_W), .HDR_W(HDR_W)
  ) classify_i (
    .hdr_valid   (hdr_valid),
    .hdr_port    (hdr_port),
    .hdr_route   (hdr_route),
    .hdr_word    (hdr_word),
    .cfg_port_en (cfg_port_en),
    .cfg_vpi_chk (cfg_vpi_chk),
    .cfg_vci_max (cfg_vci_max),
    .cfg_vpi_used(cfg_vpi_used),
    .cfg_phy_mode(cfg_phy_mode),
    .fault       (fault),
    .port_live   (port_live)
  );

  always_comb begin
    irq_evt          = '0;
    irq_evt[IRQ_GEN] = fault.bad;
    irq_evt[IRQ_VCI] = fault.vci_over;
    irq_evt[IRQ_VPI] = fault.vpi_over;
    sel_hit = port_live && cfg_cap_sel[hdr_port];
  end

  misroute_irq #(.N(NUM_IRQ)) irq_i (
    .clk  (clk),
    .rst_n(rst_n),
    .evt  (irq_evt),
    .en   (cfg_irq_en),
    .clr  (irq_clear),
    .flags(irq_flags)
  );

  misroute_capture #(.PORT_W(PORT_W), .HDR_W(HDR_W)) capture_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm_capture),
    .hit        (fault.bad),
    .sel        (sel_hit),
    .hdr_word   (hdr_word),
    .hdr_port   (hdr_port),
    .cap_hi     (cap_hi),
    .cap_lo     (cap_lo),
    .cap_port   (cap_port),
    .cap_latched(cap_latched)
  );

  p_disabled_port_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !cfg_port_en[hdr_port] |=> (irq_flags & ~$past(irq_flags)) == 3'b000)
    else $error("disabled port raised a flag");

  p_sub_implies_general_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_irq_en[0] && (fault.vci_over || fault.vpi_over) |=> irq_flags[0])
    else $error("range fault without general flag");
endmodule

// File: tb/misroute_monitor_tb_top.sv
module misroute_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdr_valid = 1'b0;
  logic [1:0]  hdr_port = '0;
  logic [1:0]  hdr_route = '0;
  logic [31:0] hdr_word = '0;
  logic [3:0]  cfg_port_en = 4'b1011;
  logic [3:0]  cfg_vpi_chk = 4'b0010;
  logic [63:0] cfg_vci_max = {16'd1000, 16'd50, 16'd200, 16'd100};
  logic [3:0]  cfg_vpi_used = 4'd8;
  logic        cfg_phy_mode = 1'b0;
  logic [2:0]  cfg_irq_en = 3'b111;
  logic [3:0]  cfg_cap_sel = 4'b1010;
  logic        arm_capture = 1'b0;
  logic [2:0]  irq_clear = '0;
  logic [2:0]  irq_flags;
  logic [15:0] cap_hi, cap_lo;
  logic [1:0]  cap_port;
  logic        cap_latched;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  misroute_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_port(hdr_port),
    .hdr_route(hdr_route), .hdr_word(hdr_word), .cfg_port_en(cfg_port_en),
    .cfg_vpi_chk(cfg_vpi_chk), .cfg_vci_max(cfg_vci_max), .cfg_vpi_used(cfg_vpi_used),
    .cfg_phy_mode(cfg_phy_mode), .cfg_irq_en(cfg_irq_en), .cfg_cap_sel(cfg_cap_sel),
    .arm_capture(arm_capture), .irq_clear(irq_clear), .irq_flags(irq_flags),
    .cap_hi(cap_hi), .cap_lo(cap_lo), .cap_port(cap_port), .cap_latched(cap_latched)
  );

  // behavioural reference model
  int m_irq, m_hi, m_lo, m_port, m_lat, m_arm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irq = 0; m_hi = 0; m_lo = 0; m_port = 0; m_lat = 0; m_arm = 0;
    end else begin
      int p, lk, vpi, vci, lim, ev;
      bit live, vbad, pbad, bad;
      p    = int'(hdr_port);
      lk   = cfg_phy_mode ? 0 : p;
      vpi  = int'(hdr_word) >>> 20 & 'hFFF;
      vci  = (int'(hdr_word) >> 4) & 'hFFFF;
      lim  = int'((cfg_vci_max >> (16 * lk)) & 64'hFFFF);
      live = hdr_valid && cfg_port_en[p];
      vbad = vci > lim;
      pbad = cfg_vpi_chk[lk] && ((vpi >> int'(cfg_vpi_used)) != 0);
      bad  = live && (hdr_route == 2'b00 || vbad || pbad);
      ev   = (bad ? 1 : 0) + ((live && vbad) ? 2 : 0) + ((live && pbad) ? 4 : 0);
      m_irq = (m_irq & ~int'(irq_clear)) | (ev & int'(cfg_irq_en));
      if (arm_capture) begin
        m_arm = 1; m_lat = 0;
      end else if (m_arm == 1 && bad && cfg_cap_sel[p]) begin
        m_hi = int'(hdr_word[31:16]); m_lo = int'(hdr_word[15:0]);
        m_port = p; m_lat = 1; m_arm = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if (int'(irq_flags) != m_irq || int'(cap_hi) != m_hi || int'(cap_lo) != m_lo ||
          int'(cap_port) != m_port || int'(cap_latched) != m_lat) begin
        n_bad++;
        $display("FAIL model R2 R3 R4 R7 at %0t: act irq=%0h hi=%0h lo=%0h port=%0d lat=%0d exp irq=%0h hi=%0h lo=%0h port=%0d lat=%0d",
                 $time, irq_flags, cap_hi, cap_lo, cap_port, cap_latched,
                 m_irq, m_hi, m_lo, m_port, m_lat);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic send(input int p, input int rt, input int vpi, input int vci,
                      input bit arm = 1'b0, input logic [2:0] clr = 3'b000);
    hdr_valid   = 1'b1;
    hdr_port    = 2'(p);
    hdr_route   = 2'(rt);
    hdr_word    = 32'((vpi << 20) | (vci << 4));
    arm_capture = arm;
    irq_clear   = clr;
    @(negedge clk);
    hdr_valid   = 1'b0;
    arm_capture = 1'b0;
    irq_clear   = '0;
  endtask

  task automatic idle(input bit arm = 1'b0, input logic [2:0] clr = 3'b000);
    arm_capture = arm;
    irq_clear   = clr;
    @(negedge clk);
    arm_capture = 1'b0;
    irq_clear   = '0;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 irq", int'(irq_flags), 0);
    chk("R1 cap", int'({cap_hi, cap_lo}), 0);
    chk("R1 latched", int'(cap_latched), 0);

    idle(1'b1);
    // R2 healthy cell raises nothing
    send(0, 1, 0, 10);
    chk("R2 clean", int'(irq_flags), 0);

    // R11: before the edge no change; after it set
    hdr_valid = 1'b1; hdr_port = 2'd0; hdr_route = 2'b00; hdr_word = 32'(10 << 4);
    #5;
    chk("R11 before edge", int'(irq_flags), 0);
    @(negedge clk);
    hdr_valid = 1'b0;
    chk("R2 route zero", int'(irq_flags), 1);
    chk("R7 unselected port", int'(cap_latched), 0);

    idle(1'b0, 3'b001);
    chk("R6 clear", int'(irq_flags), 0);

    send(1, 1, 5, 300);
    chk("R3 vci over", int'(irq_flags), 3);
    chk("R7 hi", int'(cap_hi), 'h0050);
    chk("R7 lo", int'(cap_lo), 'h12C0);
    chk("R7 port", int'(cap_port), 1);
    chk("R7 latched", int'(cap_latched), 1);

    send(3, 1, 0, 2000);
    chk("R7 one-shot hi", int'(cap_hi), 'h0050);
    chk("R7 one-shot port", int'(cap_port), 1);

    idle(1'b1);
    chk("R8 arm clears", int'(cap_latched), 0);
    chk("R8 arm keeps", int'(cap_lo), 'h12C0);

    send(3, 0, 0, 5, 1'b1);
    chk("R8 same-cycle", int'(cap_latched), 0);
    chk("R8 same-cycle port", int'(cap_port), 1);

    idle(1'b0, 3'b111);
    send(1, 1, 'h100, 5);
    chk("R4 vpi over", int'(irq_flags), 5);
    chk("R7 capture port1", int'(cap_hi), 'h1000);
    chk("R7 capture lo", int'(cap_lo), 'h0050);

    idle(1'b0, 3'b111);
    send(0, 1, 'h100, 5);
    chk("R4 check off", int'(irq_flags), 0);

    send(2, 0, 'hFFF, 9999);
    chk("R9 disabled port", int'(irq_flags), 0);
    chk("R9 capture", int'(cap_hi), 'h1000);

    cfg_irq_en = 3'b010;
    send(0, 0, 0, 500);
    chk("R5 enable gate", int'(irq_flags), 2);
    cfg_irq_en = 3'b111;

    send(3, 1, 0, 2000, 1'b0, 3'b010);
    chk("R6 set wins", int'(irq_flags), 3);

    idle(1'b0, 3'b111);
    cfg_phy_mode = 1'b1;
    send(3, 1, 0, 150);
    chk("R10 phy limit", int'(irq_flags), 3);
    idle(1'b0, 3'b111);
    send(1, 1, 'h100, 5);
    chk("R10 phy vpi check", int'(irq_flags), 0);
    cfg_phy_mode = 1'b0;

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule